// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Output Pipeline

This block is a true dual-port synchronous memory of 18-bit words, split into two 9-bit byte lanes. Each of its two ports runs on its own clock and registers its address, write data, byte enables, chip selects and read/write strobe on the rising edge of that clock. Either port may read or write any word, and both ports may address the same word in the same cycle. A write changes only the byte lanes whose enables are active. The depth is set by an address-width parameter, so the same code serves a full 18-bit address, a 17-bit variant, or a small configuration for simulation.

Each port has a mode input that chooses how read data reaches the port. In flow-through mode the word appears in the cycle that follows the edge on which the address was captured. In pipelined mode an extra output register adds one cycle. In that mode the select and byte-enable state passes through the same extra register, so a port that is deselected keeps presenting the previous read for one more cycle. There is no tri-state driver. Each byte lane of the read data has its own valid flag. A lane whose flag is low reads as zero. An asynchronous output-enable input forces all the flags low.

Top module: `dpram_dual`

## Requirements
- R1: Both ports work at once and independently. Two reads of the same word in the same cycle both return it, and two writes to different words in the same cycle both take effect.
- R2: Every input of a port except output enable and mode is captured on that port's rising clock edge. A write captured at one edge is returned by a read that either port captures at any later edge.
- R3: Lane 0 is data bits 8:0 and is enabled by bit 0 of the byte-enable input. Lane 1 is bits 17:9 and is enabled by bit 1. Byte enables are active low. A write stores only the enabled lanes, and the other lane of that word keeps its old contents.
- R4: A port is selected only when chip select 0 is low and chip select 1 is high. A deselected port performs no write and returns no read data.
- R5: With the mode input low (flow-through), a read captured at edge k shows its data and valid flags from just after edge k until edge k+1.
- R6: With the mode input high (pipelined), a read captured at edge k shows its data and flags from just after edge k+1 until edge k+2. The output after an edge therefore reflects the select and byte enables captured one edge earlier, including after a deselect.
- R7: When a read is captured, the valid flag of each lane is high only if that lane's byte enable was low. A lane whose flag is low reads as zero.
- R8: While the output enable (active low) is high, all valid flags and all data bits are zero, with no clock delay.
- R9: If one port reads a word in the same cycle that the other port writes it, the read returns the contents from before the write, in both modes.
- R10: While a port's reset (active low) is asserted, its valid flags are zero. Reads captured during reset produce no output after reset is released.
- R11: A write cycle (read/write strobe low) produces no valid read data on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| cs0_a_n | input | 1 | Port A chip select 0, active low |
| cs1_a | input | 1 | Port A chip select 1, active high |
| rd_wr_a | input | 1 | Port A strobe: 1 read, 0 write |
| be_a_n | input | 2 | Port A byte-lane enables, active low |
| oe_a_n | input | 1 | Port A output enable, active low |
| pipe_a | input | 1 | Port A mode: 1 pipelined, 0 flow-through |
| addr_a | input | ADDR_W (8) | Port A word address |
| wdata_a | input | 18 | Port A write data |
| rdata_a | output | 18 | Port A read data, zero in invalid lanes |
| rvalid_a | output | 2 | Port A per-lane read-valid flags |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| cs0_b_n | input | 1 | Port B chip select 0, active low |
| cs1_b | input | 1 | Port B chip select 1, active high |
| rd_wr_b | input | 1 | Port B strobe: 1 read, 0 write |
| be_b_n | input | 2 | Port B byte-lane enables, active low |
| oe_b_n | input | 1 | Port B output enable, active low |
| pipe_b | input | 1 | Port B mode: 1 pipelined, 0 flow-through |
| addr_b | input | ADDR_W (8) | Port B word address |
| wdata_b | input | 18 | Port B write data |
| rdata_b | output | 18 | Port B read data, zero in invalid lanes |
| rvalid_b | output | 2 | Port B per-lane read-valid flags |

## Verification
A read captured at an edge is due one sample later in flow-through mode and two samples later in pipelined mode. A write becomes readable by any read captured at the next edge. Output enable and reset act at once. The bench drives inputs and samples outputs on the falling edge. For each port it keeps a two-deep history of issued operations, each holding the lanes expected and the data read from a shadow memory at issue time. Every sample is compared with the history entry that matches the port's current mode. The shadow memory takes a cycle's writes only after that cycle's reads have been recorded, which gives the read-before-write result for same-cycle accesses.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   // number of access ports on the array
   localparam int unsigned PORT_COUNT = 2;

   // read output timing choice of one port
   typedef enum logic {
      OUT_FLOW = 1'b0,
      OUT_PIPE = 1'b1
   } out_mode_e;

   // a port is active when select 0 is low and select 1 is high
   function automatic logic port_selected(input logic cs0_n, input logic cs1);
      return !cs0_n && cs1;
   endfunction

endpackage

// File: rtl/dpram_in_reg.sv
module dpram_in_reg #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs0_n,
   input  logic                      cs1,
   input  logic                      rd_wr,
   input  logic [LANES-1:0]          be_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [ADDR_W-1:0]         addr_q,
   output logic [LANES*LANE_W-1:0]   wdata_q,
   output logic [LANES-1:0]          wr_lanes_q,
   output logic [LANES-1:0]          rd_lanes_q
);

   logic sel;
   assign sel = dpram_pkg::port_selected(cs0_n, cs1);

   // control state: cleared by reset so nothing stale leaks out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_lanes_q <= '0;
         rd_lanes_q <= '0;
      end else begin
         wr_lanes_q <= (sel && !rd_wr) ? ~be_n : '0;
         rd_lanes_q <= (sel &&  rd_wr) ? ~be_n : '0;
      end
   end

   // address and data need no reset
   always_ff @(posedge clk) begin
      addr_q  <= addr;
      wdata_q <= wdata;
   end

   // R3
   wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> wr_lanes_q == (($past(sel) && !$past(rd_wr)) ? ~$past(be_n) : '0));

   // R11
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lanes_q != '0) |-> (rd_lanes_q == '0));

endmodule

// File: rtl/dpram_xor_bank.sv
module dpram_xor_bank #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int PORTS  = 2
) (
   input  logic                                clk,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [LANES-1:0]                    wr_lanes,
   input  logic [LANES*LANE_W-1:0]             wr_word,
   input  logic [PORTS-1:0][ADDR_W-1:0]        rd_addr,
   output logic [PORTS-1:0][LANES*LANE_W-1:0]  rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   // one storage array per lane, written only from this bank's clock
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_lanes[l])
            cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
      end

      for (genvar p = 0; p < PORTS; p++) begin : g_rd
         assign rd_word[p][l*LANE_W +: LANE_W] = cells[rd_addr[p]];
      end
   end

endmodule

// File: rtl/dpram_read_path.sv
module dpram_read_path #(
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pipe_mode,
   input  logic                      oe_n,
   input  logic [LANES-1:0]          rd_lanes,
   input  logic [LANES*LANE_W-1:0]   rd_word,
   output logic [LANES-1:0]          rvalid,
   output logic [LANES*LANE_W-1:0]   rdata
);

   localparam int DATA_W = LANES * LANE_W;

   dpram_pkg::out_mode_e mode;
   logic [LANES-1:0]  lanes_p;
   logic [DATA_W-1:0] word_p;
   logic [LANES-1:0]  lanes_sel;
   logic [DATA_W-1:0] word_sel;

   assign mode = dpram_pkg::out_mode_e'(pipe_mode);

   // second stage: the enables are delayed together with the data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lanes_p <= '0;
      else        lanes_p <= rd_lanes;
   end

   always_ff @(posedge clk) begin
      word_p <= rd_word;
   end

   always_comb begin
      if (mode == dpram_pkg::OUT_PIPE) begin
         lanes_sel = lanes_p;
         word_sel  = word_p;
      end else begin
         lanes_sel = rd_lanes;
         word_sel  = rd_word;
      end
   end

   assign rvalid = (oe_n || !rst_n) ? '0 : lanes_sel;

   for (genvar l = 0; l < LANES; l++) begin : g_out
      assign rdata[l*LANE_W +: LANE_W] = rvalid[l] ? word_sel[l*LANE_W +: LANE_W] : '0;

      // R6
      pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pipe_mode && rvalid[l]) |-> rdata[l*LANE_W +: LANE_W] == $past(rd_word[l*LANE_W +: LANE_W]));
   end

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                      clk_a,
   input  logic                      rst_a_n,
   input  logic                      cs0_a_n,
   input  logic                      cs1_a,
   input  logic                      rd_wr_a,
   input  logic [LANES-1:0]          be_a_n,
   input  logic                      oe_a_n,
   input  logic                      pipe_a,
   input  logic [ADDR_W-1:0]         addr_a,
   input  logic [LANES*LANE_W-1:0]   wdata_a,
   output logic [LANES*LANE_W-1:0]   rdata_a,
   output logic [LANES-1:0]          rvalid_a,
   input  logic                      clk_b,
   input  logic                      rst_b_n,
   input  logic                      cs0_b_n,
   input  logic                      cs1_b,
   input  logic                      rd_wr_b,
   input  logic [LANES-1:0]          be_b_n,
   input  logic                      oe_b_n,
   input  logic                      pipe_b,
   input  logic [ADDR_W-1:0]         addr_b,
   input  logic [LANES*LANE_W-1:0]   wdata_b,
   output logic [LANES*LANE_W-1:0]   rdata_b,
   output logic [LANES-1:0]          rvalid_b
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int NP     = dpram_pkg::PORT_COUNT;

   if (ADDR_W < 2 || ADDR_W > 18) begin : g_bad_addr_w
      $error("dpram_dual: ADDR_W must lie in 2..18");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("dpram_dual: LANES must lie in 1..4");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("dpram_dual: LANE_W must be positive");
   end
   if (NP != 2) begin : g_bad_ports
      $error("dpram_dual: the bank scheme needs exactly two ports");
   end

   // per-port views of the two port groups
   logic [NP-1:0]              clk_v, rst_v, cs0_v, cs1_v, rw_v, oe_v, pipe_v, sel_v;
   logic [NP-1:0][LANES-1:0]   be_v, rvalid_v;
   logic [NP-1:0][ADDR_W-1:0]  addr_v, addr_q_v;
   logic [NP-1:0][DATA_W-1:0]  wd_v, rdo_v, wdq_v, word_v, bank_wr_word;
   logic [NP-1:0][LANES-1:0]   wr_lanes_v, rd_lanes_v;
   logic [NP-1:0][NP-1:0][DATA_W-1:0] bank_rd;   // [bank][reading port]

   assign clk_v  = {clk_b,   clk_a};
   assign rst_v  = {rst_b_n, rst_a_n};
   assign cs0_v  = {cs0_b_n, cs0_a_n};
   assign cs1_v  = {cs1_b,   cs1_a};
   assign rw_v   = {rd_wr_b, rd_wr_a};
   assign oe_v   = {oe_b_n,  oe_a_n};
   assign pipe_v = {pipe_b,  pipe_a};
   assign be_v   = {be_b_n,  be_a_n};
   assign addr_v = {addr_b,  addr_a};
   assign wd_v   = {wdata_b, wdata_a};

   assign rdata_a  = rdo_v[0];
   assign rdata_b  = rdo_v[1];
   assign rvalid_a = rvalid_v[0];
   assign rvalid_b = rvalid_v[1];

   for (genvar p = 0; p < NP; p++) begin : g_port
      localparam int OTHER = NP - 1 - p;

      assign sel_v[p] = dpram_pkg::port_selected(cs0_v[p], cs1_v[p]);

      dpram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
         .clk        (clk_v[p]),
         .rst_n      (rst_v[p]),
         .cs0_n      (cs0_v[p]),
         .cs1        (cs1_v[p]),
         .rd_wr      (rw_v[p]),
         .be_n       (be_v[p]),
         .addr       (addr_v[p]),
         .wdata      (wd_v[p]),
         .addr_q     (addr_q_v[p]),
         .wdata_q    (wdq_v[p]),
         .wr_lanes_q (wr_lanes_v[p]),
         .rd_lanes_q (rd_lanes_v[p])
      );

      // a bank stores new data XOR the other bank, so the XOR of both is the word
      assign bank_wr_word[p] = wdq_v[p] ^ bank_rd[OTHER][p];
      assign word_v[p]       = bank_rd[0][p] ^ bank_rd[1][p];

      dpram_xor_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .PORTS(NP)) u_bank (
         .clk      (clk_v[p]),
         .wr_addr  (addr_q_v[p]),
         .wr_lanes (wr_lanes_v[p]),
         .wr_word  (bank_wr_word[p]),
         .rd_addr  (addr_q_v),
         .rd_word  (bank_rd[p])
      );

      dpram_read_path #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
         .clk       (clk_v[p]),
         .rst_n     (rst_v[p]),
         .pipe_mode (pipe_v[p]),
         .oe_n      (oe_v[p]),
         .rd_lanes  (rd_lanes_v[p]),
         .rd_word   (word_v[p]),
         .rvalid    (rvalid_v[p]),
         .rdata     (rdo_v[p])
      );

      // R5
      ft_latency_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
         (!pipe_v[p] && !oe_v[p] && $past(rst_v[p])) |->
            rvalid_v[p] == (($past(sel_v[p]) && $past(rw_v[p])) ? ~$past(be_v[p]) : '0));

      // R6
      pipe_latency_chk: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
         (pipe_v[p] && !oe_v[p] && $past(rst_v[p]) && $past(rst_v[p], 2)) |->
            rvalid_v[p] == (($past(sel_v[p], 2) && $past(rw_v[p], 2)) ? ~$past(be_v[p], 2) : '0));
   end

endmodule

// File: tb/tb_dpram_dual.sv
module tb_dpram_dual;

   localparam int AW = 4;
   localparam int NW = 1 << AW;

   logic        clk;
   logic        rst_n;
   logic        cs0_n [2];
   logic        cs1   [2];
   logic        rw    [2];
   logic [1:0]  be_n  [2];
   logic        oe_n  [2];
   logic        pipe  [2];
   logic [AW-1:0] addr [2];
   logic [17:0] wd    [2];
   logic [17:0] rdq   [2];
   logic [1:0]  rv    [2];

   // next operation, applied at the following step
   logic        n_rst;
   logic        n_cs0_n [2];
   logic        n_cs1   [2];
   logic        n_rw    [2];
   logic [1:0]  n_be    [2];
   logic        n_oe    [2];
   logic        n_pipe  [2];
   logic [AW-1:0] n_addr [2];
   logic [17:0] n_wd    [2];

   // shadow memory and per-port history: index 0 newest, 1 one step older
   logic [17:0] mem    [NW];
   logic [1:0]  h_lane [2][2];
   logic [17:0] h_data [2][2];

   int    n_checks = 0;
   int    n_err    = 0;
   string tag      = "R10";

   dpram_dual #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) dut (
      .clk_a(clk), .rst_a_n(rst_n), .cs0_a_n(cs0_n[0]), .cs1_a(cs1[0]), .rd_wr_a(rw[0]),
      .be_a_n(be_n[0]), .oe_a_n(oe_n[0]), .pipe_a(pipe[0]), .addr_a(addr[0]), .wdata_a(wd[0]),
      .rdata_a(rdq[0]), .rvalid_a(rv[0]),
      .clk_b(clk), .rst_b_n(rst_n), .cs0_b_n(cs0_n[1]), .cs1_b(cs1[1]), .rd_wr_b(rw[1]),
      .be_b_n(be_n[1]), .oe_b_n(oe_n[1]), .pipe_b(pipe[1]), .addr_b(addr[1]), .wdata_b(wd[1]),
      .rdata_b(rdq[1]), .rvalid_b(rv[1])
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [17:0] pat(input int a, input int k);
      logic [17:0] v;
      v = 18'(a * 7919 + k * 40503 + 1234);
      return v ^ {v[8:0], v[17:9]};
   endfunction

   task automatic set_idle(input int p);
      n_cs0_n[p] = 1'b1; n_cs1[p] = 1'b0; n_rw[p] = 1'b1; n_be[p] = 2'b11;
   endtask

   task automatic set_rd(input int p, input int a, input logic [1:0] be);
      n_cs0_n[p] = 1'b0; n_cs1[p] = 1'b1; n_rw[p] = 1'b1; n_be[p] = be;
      n_addr[p] = AW'(a);
   endtask

   task automatic set_wr(input int p, input int a, input logic [1:0] be, input logic [17:0] d);
      n_cs0_n[p] = 1'b0; n_cs1[p] = 1'b1; n_rw[p] = 1'b0; n_be[p] = be;
      n_addr[p] = AW'(a); n_wd[p] = d;
   endtask

   // one falling-edge step: check outputs, record the new operations, drive pins
   task automatic step();
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         logic [1:0]  el;
         logic [17:0] ed;
         el = pipe[p] ? h_lane[p][1] : h_lane[p][0];
         if (oe_n[p] || !rst_n) el = 2'b00;
         ed = (pipe[p] ? h_data[p][1] : h_data[p][0]) & {{9{el[1]}}, {9{el[0]}}};
         n_checks++;
         if (rv[p] !== el || rdq[p] !== ed) begin
            n_err++;
            $display("FAIL %s port %0d: rvalid=%b rdata=%h, expected rvalid=%b rdata=%h",
                     tag, p, rv[p], rdq[p], el, ed);
         end
      end
      for (int p = 0; p < 2; p++) begin
         logic sel;
         sel = !n_cs0_n[p] && n_cs1[p];
         h_lane[p][1] = h_lane[p][0];
         h_data[p][1] = h_data[p][0];
         h_lane[p][0] = (n_rst && sel && n_rw[p]) ? ~n_be[p] : 2'b00;
         h_data[p][0] = mem[n_addr[p]];
         if (!rst_n || !n_rst) begin
            h_lane[p][1] = 2'b00;
         end
      end
      for (int p = 0; p < 2; p++) begin
         if (n_rst && !n_cs0_n[p] && n_cs1[p] && !n_rw[p]) begin
            if (!n_be[p][0]) mem[n_addr[p]][8:0]  = n_wd[p][8:0];
            if (!n_be[p][1]) mem[n_addr[p]][17:9] = n_wd[p][17:9];
         end
      end
      rst_n = n_rst;
      for (int p = 0; p < 2; p++) begin
         cs0_n[p] = n_cs0_n[p]; cs1[p] = n_cs1[p]; rw[p] = n_rw[p]; be_n[p] = n_be[p];
         oe_n[p] = n_oe[p]; pipe[p] = n_pipe[p]; addr[p] = n_addr[p]; wd[p] = n_wd[p];
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; n_rst = 1'b0;
      for (int i = 0; i < NW; i++) mem[i] = '0;
      for (int p = 0; p < 2; p++) begin
         set_idle(p);
         n_oe[p] = 1'b0; n_pipe[p] = 1'b0; n_addr[p] = '0; n_wd[p] = '0;
         cs0_n[p] = 1'b1; cs1[p] = 1'b0; rw[p] = 1'b1; be_n[p] = 2'b11;
         oe_n[p] = 1'b0; pipe[p] = 1'b0; addr[p] = '0; wd[p] = '0;
         for (int k = 0; k < 2; k++) begin h_lane[p][k] = 2'b00; h_data[p][k] = '0; end
      end

      // R10: reads issued during reset give nothing, during or after
      tag = "R10";
      set_rd(0, 3, 2'b00); set_rd(1, 5, 2'b00); n_pipe[1] = 1'b1;
      repeat (4) step();
      n_rst = 1'b1; set_idle(0); set_idle(1);
      repeat (3) step();

      // R1: simultaneous writes to different words
      tag = "R1";
      for (int a = 0; a < NW / 2; a++) begin
         set_wr(0, a, 2'b00, pat(a, 0)); set_wr(1, a + NW / 2, 2'b00, pat(a + NW / 2, 0));
         step();
      end
      set_idle(0); set_idle(1); n_pipe[1] = 1'b0;

      // R2: a read captured at the next edge returns the new word
      tag = "R2";
      for (int a = 0; a < 4; a++) begin
         set_wr(0, a, 2'b00, pat(a, 1)); step();
         set_rd(0, a, 2'b00); set_rd(1, a, 2'b00); step();
         set_idle(1);
      end

      // R3: lane-masked writes, lower lane from A, upper lane from B
      tag = "R3";
      for (int a = 0; a < NW; a++) begin
         set_wr(0, a, 2'b10, pat(a, 2));
         set_wr(1, (a + NW / 2) % NW, 2'b01, pat(a, 3));
         step();
      end
      set_idle(1);

      // R5: flow-through sweep on port A
      tag = "R5";
      n_pipe[0] = 1'b0;
      for (int a = 0; a < NW; a++) begin set_rd(0, a, 2'b00); step(); end
      set_idle(0);

      // R6: pipelined sweep on port B, then deselects inside a read run
      tag = "R6";
      n_pipe[1] = 1'b1;
      for (int a = 0; a < NW; a++) begin set_rd(1, a, 2'b00); step(); end
      for (int i = 0; i < 9; i++) begin
         if (i % 3 == 0) set_idle(1); else set_rd(1, i, 2'b00);
         step();
      end

      // R1: both ports read the same word in the same cycle
      tag = "R1";
      for (int a = 0; a < NW; a++) begin set_rd(0, a, 2'b00); set_rd(1, a, 2'b00); step(); end

      // R7: every byte-enable pattern on reads
      tag = "R7";
      for (int i = 0; i < NW; i++) begin
         set_rd(0, i, 2'(i)); set_rd(1, NW - 1 - i, 2'(i >> 2)); step();
      end

      // R4: each select off, including a write that must not land
      tag = "R4";
      for (int i = 0; i < 12; i++) begin
         case (i % 4)
            0: begin set_rd(0, i, 2'b00); n_cs0_n[0] = 1'b1; end
            1: begin set_rd(0, i, 2'b00); n_cs1[0] = 1'b0; end
            2: begin set_wr(0, i, 2'b00, 18'h3FFFF); n_cs1[0] = 1'b0; end
            default: set_rd(0, i - 1, 2'b00);
         endcase
         if (i % 2 == 0) begin set_wr(1, i + 2, 2'b00, 18'h155AA); n_cs0_n[1] = 1'b1; end
         else set_rd(1, i + 1, 2'b00);
         step();
      end

      // R8: output enable toggling during reads
      tag = "R8";
      for (int i = 0; i < 12; i++) begin
         set_rd(0, i, 2'b00); set_rd(1, i + 3, 2'b00);
         n_oe[0] = i[0]; n_oe[1] = ~i[1];
         step();
      end
      n_oe[0] = 1'b0; n_oe[1] = 1'b0;

      // R11: write cycles give no read output
      tag = "R11";
      for (int i = 0; i < 12; i++) begin
         if (i % 2 == 0) set_wr(0, i, 2'b00, pat(i, 4)); else set_rd(0, i - 1, 2'b00);
         set_rd(1, i + 2, 2'b00);
         step();
      end

      // R9: B reads the word A writes in the same cycle, both modes
      tag = "R9";
      for (int a = 0; a < 8; a++) begin
         n_pipe[1] = (a >= 4);
         set_wr(0, a, 2'b00, pat(a, 5)); set_rd(1, a, 2'b00); step();
         set_idle(0); set_rd(1, a, 2'b00); step();
      end

      set_idle(0); set_idle(1);
      repeat (3) step();
      summary();
      $finish;
   end

endmodule